// File: doc/BRIEF.md
# Pipelined Histogram Bin Array with Two-Slow Counters

This block builds a histogram of a pixel stream that arrives at one pixel per clock, one bin per pixel value. It is a linear chain of cells, one for each bin. Each pixel moves through the chain from left to right with a single register per cell. The cell whose bin value equals the pixel adds one to its count.

Each cell's count loop is retimed by a factor of two. Two registers sit in the feedback path, so two interleaved partial counts build up, one from even cycles and one from odd cycles. A registered adder merges the two partials into the bin total. The pixel path is not slowed by this.

Software clears the array with a one-cycle clear pulse before a frame, then streams pixels with a valid qualifier. After the pipeline drains it pulses a read start. The merged totals are loaded into a registered shift chain and leave through one output port, lowest bin first, with a valid flag.

Top module: `hist_array`

## Requirements
- R1: After reset, and before any read start, `rd_valid` is 0 and `rd_data` is 0.
- R2: Each pixel accepted with `in_valid`=1 and value v (v < NUM_BINS) adds exactly one to bin v and to no other bin.
- R3: A cycle with `in_valid`=0 changes no bin, whatever value `in_pix` carries.
- R4: Pixels accepted on consecutive cycles are all counted. This covers runs of one value and runs that alternate between two values, so both interleaved partial counts are exercised.
- R5: A one-cycle `clr` pulse, given while no pixel is in flight, sets every bin to 0.
- R6: A read start sampled at edge E puts bin k on `rd_data` after edge E+k, for k = 0..NUM_BINS-1. `rd_valid` is 1 for exactly those NUM_BINS cycles. `rd_data` is 0 whenever `rd_valid` is 0.
- R7: A pixel accepted at edge E is included in any read start sampled at edge E+NUM_BINS+2 or later, even for the last bin.
- R8: A bin holds counts up to 2^CNT_W-1 without wrap. A single bin fed 600 back-to-back pixels reads back 600.
- R9: No bin ever reads back more than the number of pixels accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all bin counts |
| in_valid | input | 1 | Qualifies `in_pix` in this cycle |
| in_pix | input | PIX_W | Pixel value |
| rd_start | input | 1 | Loads all bin totals into the read chain |
| rd_valid | output | 1 | `rd_data` carries a bin count |
| rd_data | output | CNT_W | Bin count, bin 0 first |

## Verification
The hardest case to reach is a pixel for the last bin being counted in time for the earliest read that may include it. That read has to land exactly NUM_BINS+2 edges after the pixel, so a late pixel cannot be hidden by a generous drain wait. A directed test sends one such pixel and starts the read on that exact edge.

Long back-to-back runs of one value, and runs alternating between two values, make both interleaved partial counters carry the count. If the merge adder were wrong, these runs would show it. Random frames with idle gaps, during which `in_pix` keeps changing, cover the valid qualifier.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic {
    RD_SHIFT = 1'b0,
    RD_LOAD  = 1'b1
  } rd_op_e;
endpackage

// File: rtl/hist_cslow_acc.sv
// Two-slow accumulator: two registers in the feedback loop build
// interleaved partial sums; a registered adder merges them.
module hist_cslow_acc #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] part_a;
  logic [CNT_W-1:0] part_b;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      part_a <= '0;
      part_b <= '0;
      total  <= '0;
    end else begin
      part_a <= part_b + CNT_W'(inc);
      part_b <= part_a;
      total  <= part_a + part_b;
    end
  end
endmodule

// File: rtl/hist_cell.sv
module hist_cell
  import hist_pkg::*;
#(
  parameter int PIX_W  = 3,
  parameter int CNT_W  = 19,
  parameter int BIN_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pix_vld_in,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_vld_out,
  output logic [PIX_W-1:0] pix_out,
  input  rd_op_e           rd_op,
  input  logic             rd_vld_next,
  input  logic [CNT_W-1:0] rd_cnt_next,
  output logic             rd_vld_q,
  output logic [CNT_W-1:0] rd_cnt_q
);
  localparam logic [PIX_W-1:0] BIN_VAL = PIX_W'(BIN_ID);

  logic             hit;
  logic [CNT_W-1:0] bin_total;

  assign hit = pix_vld_in && (pix_in == BIN_VAL);

  // One pixel register per cell: the pixel path is not slowed.
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_vld_out <= 1'b0;
      pix_out     <= '0;
    end else begin
      pix_vld_out <= pix_vld_in;
      pix_out     <= pix_in;
    end
  end

  hist_cslow_acc #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (hit),
    .total (bin_total)
  );

  // Registered read multiplexer: own total on load, neighbour otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q <= 1'b0;
      rd_cnt_q <= '0;
    end else if (rd_op == RD_LOAD) begin
      rd_vld_q <= 1'b1;
      rd_cnt_q <= bin_total;
    end else begin
      rd_vld_q <= rd_vld_next;
      rd_cnt_q <= rd_cnt_next;
    end
  end
endmodule

// File: rtl/hist_array.sv
module hist_array
  import hist_pkg::*;
#(
  parameter int PIX_W    = 3,
  parameter int NUM_BINS = 8,
  parameter int CNT_W    = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             rd_start,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NSTAGE = NUM_BINS + 1;

  logic             pix_vld [NSTAGE];
  logic [PIX_W-1:0] pix_bus [NSTAGE];
  logic             rd_vld  [NSTAGE];
  logic [CNT_W-1:0] rd_cnt  [NSTAGE];
  rd_op_e           rd_op;

  assign rd_op = rd_start ? RD_LOAD : RD_SHIFT;

  // Input register, stage 0 of the pixel path.
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_vld[0] <= 1'b0;
      pix_bus[0] <= '0;
    end else begin
      pix_vld[0] <= in_valid;
      pix_bus[0] <= in_pix;
    end
  end

  // Tail of the read chain feeds zeros.
  assign rd_vld[NUM_BINS] = 1'b0;
  assign rd_cnt[NUM_BINS] = '0;

  for (genvar i = 0; i < NUM_BINS; i++) begin : g_cell
    hist_cell #(
      .PIX_W  (PIX_W),
      .CNT_W  (CNT_W),
      .BIN_ID (i)
    ) u_cell (
      .clk         (clk),
      .rst         (rst),
      .clr         (clr),
      .pix_vld_in  (pix_vld[i]),
      .pix_in      (pix_bus[i]),
      .pix_vld_out (pix_vld[i+1]),
      .pix_out     (pix_bus[i+1]),
      .rd_op       (rd_op),
      .rd_vld_next (rd_vld[i+1]),
      .rd_cnt_next (rd_cnt[i+1]),
      .rd_vld_q    (rd_vld[i]),
      .rd_cnt_q    (rd_cnt[i])
    );
  end

  assign rd_valid = rd_vld[0];
  assign rd_data  = rd_cnt[0];
endmodule

// File: rtl/hist_array_chk.sv
module hist_array_chk #(
  parameter int NUM_BINS = 8,
  parameter int CNT_W    = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             rd_start,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rd_data
);
  logic [31:0] since_start;
  logic [31:0] seen_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_start <= 32'(NUM_BINS);
      seen_pix    <= '0;
    end else begin
      if (rd_start) since_start <= '0;
      else if (since_start < 32'(NUM_BINS)) since_start <= since_start + 1;
      if (in_valid) seen_pix <= seen_pix + 1;
    end
  end

  // R1: no output beat without a read start
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && !rd_start) |=> !rd_valid);

  // R6: valid for exactly NUM_BINS cycles after a start
  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (since_start < 32'(NUM_BINS)));

  // R6: data is zero outside the valid window
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R9: a bin never exceeds pixels accepted since reset
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (32'(rd_data) <= seen_pix));
endmodule

bind hist_array hist_array_chk #(
  .NUM_BINS (NUM_BINS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .rd_start (rd_start),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/hist_array_tb.sv
module hist_array_tb;
  localparam int PIX_W    = 3;
  localparam int NUM_BINS = 8;
  localparam int CNT_W    = 19;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clr = 1'b0;
  logic             in_valid = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             rd_start = 1'b0;
  logic             rd_valid;
  logic [CNT_W-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_cnt [NUM_BINS];

  always #2 clk = ~clk;

  hist_array #(.PIX_W(PIX_W), .NUM_BINS(NUM_BINS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_pix(in_pix),
    .rd_start(rd_start), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic send(input int v, input logic vld);
    in_pix   = PIX_W'(v);
    in_valid = vld;
    @(negedge clk);
    if (vld) ref_cnt[v]++;
    in_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int b = 0; b < NUM_BINS; b++) ref_cnt[b] = 0;
  endtask

  // Start sampled NUM_BINS+2 edges after the last accepting edge (R7).
  task automatic drain();
    in_valid = 1'b0;
    repeat (NUM_BINS + 1) @(negedge clk);
  endtask

  task automatic read_all(input string req);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    for (int k = 0; k < NUM_BINS; k++) begin
      check({req, " R6 valid"}, int'(rd_valid), 1);
      check({req, $sformatf(" bin%0d", k)}, int'(rd_data), ref_cnt[k]);
      @(negedge clk);
    end
    check({req, " R6 valid low after"}, int'(rd_valid), 0);
    check({req, " R6 data zero after"}, int'(rd_data), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    for (int b = 0; b < NUM_BINS; b++) ref_cnt[b] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(rd_valid), 0);
    check("R1 data after reset", int'(rd_data), 0);
    repeat (3) @(negedge clk);
    check("R1 valid stays low", int'(rd_valid), 0);

    // R2/R4: alternating two values back to back
    do_clear();
    for (int i = 0; i < 41; i++) send((i % 2 == 0) ? 2 : 6, 1'b1);
    drain();
    read_all("R4 alternating");

    // R8/R4: one bin, long run
    do_clear();
    for (int i = 0; i < 600; i++) send(5, 1'b1);
    drain();
    read_all("R8 long run");

    // R5/R3: clear then idle cycles with changing pixel values
    do_clear();
    for (int i = 0; i < 50; i++) send(i % NUM_BINS, 1'b0);
    drain();
    read_all("R5 R3 cleared idle");

    // R7: last bin pixel, earliest legal read
    do_clear();
    send(NUM_BINS - 1, 1'b1);
    drain();
    read_all("R7 last bin latency");

    // R2: single pixel per bin in sequence
    do_clear();
    for (int v = 0; v < NUM_BINS; v++) send(v, 1'b1);
    drain();
    read_all("R2 sweep");

    // R2/R3: random frames with idle gaps
    for (int f = 0; f < 4; f++) begin
      do_clear();
      for (int i = 0; i < 300; i++)
        send(int'($urandom_range(NUM_BINS - 1)), ($urandom_range(9) > 2));
      drain();
      read_all($sformatf("R2 R3 random frame %0d", f));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule